// File: doc/BRIEF.md
# 8B/10B Symbol Encoder with Disparity Override

This block turns one byte plus a control flag into a 10-bit line symbol on every strobed clock. It uses the usual 5b/6b and 3b/4b sub-block code sets and keeps a running disparity bit. That bit picks between the negative-column and positive-column codes, so the line stays DC-balanced. Running disparity is negative when reset ends. It flips each time an unbalanced sub-block code is sent.

An override is provided for each symbol. While `force_en` is high, the column is chosen from `force_rd` and not from the tracked disparity. Tracking then carries on from whatever disparity the forced symbol leaves behind. Control characters are accepted only for the twelve legal K codes. Any other byte flagged as control sets an error output and is sent as the data character of the same value.

Top module: `sym8b10b_enc`

## Requirements
- R1: While `rst_n` is low and after it is released, `sym_out` is 0, `kerr_out` is 0 and `rd_out` is 0 (0 = negative disparity, 1 = positive) until the first strobed symbol.
- R2: Each symbol shows up on `sym_out` one clock after the edge that samples it with `sym_vld` high. While `sym_vld` is low, `sym_out`, `rd_out` and `kerr_out` keep their values whatever the other inputs do.
- R3: Data symbols use the standard 5b/6b and 3b/4b code sets. The input bits are HGFEDCBA = `byte_in[7:0]`, with x = EDCBA and y = HGF. The output is `sym_out[9:4]` = abcdei with a at bit 9, and `sym_out[3:0]` = fghj with f at bit 3. Bit 9 is sent first. Examples: D21.5 = 10'h2AA in either column; D0.0 from negative disparity = 10'h274.
- R4: Each sub-block updates disparity. The 3b/4b sub-block uses the disparity left by the 5b/6b sub-block. Every symbol has 4, 5 or 6 ones.
- R5: With `force_en` high, the symbol is encoded from the column given by `force_rd`. `rd_out` then reflects the disparity that results from that forced symbol.
- R6: D.x.7 uses the alternate 3b/4b code in two cases: disparity is negative and x is 17, 18 or 20 (code 0111), or disparity is positive and x is 11, 13 or 14 (code 1000). Examples: D17.7 from negative = 10'h237; D11.7 from positive = 10'h348.
- R7: With `is_k` high, K28.0 through K28.7, K23.7, K27.7, K29.7 and K30.7 are encoded as control symbols. Examples: K28.5 = 10'h0FA from negative and 10'h305 from positive; K28.7 from negative = 10'h0F8.
- R8: With `is_k` high and any other byte, `kerr_out` is 1 for that symbol and the byte is encoded as the data character. For a legal K code, or whenever `is_k` is low, `kerr_out` is 0.
- R9: `rd_out` is the running disparity after the last strobed symbol. It is the column used by the next symbol unless that symbol is forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_vld | input | 1 | Input strobe; a symbol is encoded when high |
| byte_in | input | 8 | Byte to encode, HGFEDCBA |
| is_k | input | 1 | Byte is a control character |
| force_en | input | 1 | Override the disparity column for this symbol |
| force_rd | input | 1 | Forced disparity, 0 negative, 1 positive |
| sym_out | output | 10 | Registered symbol, abcdei fghj, bit 9 first |
| rd_out | output | 1 | Current running disparity |
| kerr_out | output | 1 | Registered illegal-control flag |

## Verification
The bench checks every legal K code and the D.x.7 alternate cases against the running disparity. A design that picked the alternate from the wrong disparity would emit runs of five equal bits, and the bytes that differ would mismatch. It forces the column against the tracked disparity in both directions. A design that ignored the override, or resumed from the old disparity, would show a wrong `rd_out` on the next symbol. It also sends illegal control bytes and idle cycles with changing inputs, which catches a missing error flag, a control code sent for a bad byte, or outputs that move without a strobe.

// File: rtl/sym_enc_pkg.sv
package sym_enc_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned SYM_W  = 10;
   localparam int unsigned SB6_W  = 6;
   localparam int unsigned SB4_W  = 4;

   typedef enum logic {RD_NEG = 1'b0, RD_POS = 1'b1} rd_e;

   // legal control characters: every K28.y, and K.x.7 for x in 23, 27, 29, 30
   function automatic logic k_legal(input logic [7:0] b);
      logic [4:0] x;
      logic [2:0] y;
      x = b[4:0];
      y = b[7:5];
      if (x == 5'd28) return 1'b1;
      if (y == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30))
         return 1'b1;
      return 1'b0;
   endfunction

endpackage

// File: rtl/sym_enc_6b.sv
module sym_enc_6b
   import sym_enc_pkg::*;
#(
   parameter int unsigned IN_W  = 5,
   parameter int unsigned OUT_W = 6
) (
   input  logic [IN_W-1:0]  x_in,
   input  logic             k28,
   input  logic             rd_in,
   output logic [OUT_W-1:0] code,
   output logic             rd_nxt
);
   localparam int unsigned HALF = OUT_W / 2;

   if (IN_W != 5 || OUT_W != 6) begin : g_bad_w
      $error("sym_enc_6b: widths fixed at 5 in, 6 out");
   end

   logic [OUT_W-1:0] neg_code;
   logic             unbal;
   logic             swap;

   always_comb begin
      unique case (x_in)
         5'd0:  neg_code = 6'b100111;
         5'd1:  neg_code = 6'b011101;
         5'd2:  neg_code = 6'b101101;
         5'd3:  neg_code = 6'b110001;
         5'd4:  neg_code = 6'b110101;
         5'd5:  neg_code = 6'b101001;
         5'd6:  neg_code = 6'b011001;
         5'd7:  neg_code = 6'b111000;
         5'd8:  neg_code = 6'b111001;
         5'd9:  neg_code = 6'b100101;
         5'd10: neg_code = 6'b010101;
         5'd11: neg_code = 6'b110100;
         5'd12: neg_code = 6'b001101;
         5'd13: neg_code = 6'b101100;
         5'd14: neg_code = 6'b011100;
         5'd15: neg_code = 6'b010111;
         5'd16: neg_code = 6'b011011;
         5'd17: neg_code = 6'b100011;
         5'd18: neg_code = 6'b010011;
         5'd19: neg_code = 6'b110010;
         5'd20: neg_code = 6'b001011;
         5'd21: neg_code = 6'b101010;
         5'd22: neg_code = 6'b011010;
         5'd23: neg_code = 6'b111010;
         5'd24: neg_code = 6'b110011;
         5'd25: neg_code = 6'b100110;
         5'd26: neg_code = 6'b010110;
         5'd27: neg_code = 6'b110110;
         5'd28: neg_code = k28 ? 6'b001111 : 6'b001110;
         5'd29: neg_code = 6'b101110;
         5'd30: neg_code = 6'b011110;
         default: neg_code = 6'b101011;
      endcase
      unbal  = ($countones(neg_code) != HALF);
      // D.7 is balanced yet has a distinct positive-column form
      swap   = rd_in && (unbal || (x_in == 5'd7 && !k28));
      code   = swap ? ~neg_code : neg_code;
      rd_nxt = rd_in ^ unbal;
   end

   // R4: positive column never carries more ones than zeros, negative never fewer
   always_comb begin
      a_r4_col6: assert (rd_in ? ($countones(code) <= HALF) : ($countones(code) >= HALF))
         else $error("6b column mismatch");
   end

endmodule

// File: rtl/sym_enc_4b.sv
module sym_enc_4b
   import sym_enc_pkg::*;
#(
   parameter int unsigned OUT_W = 4
) (
   input  logic [2:0]       y_in,
   input  logic [4:0]       x_in,
   input  logic             k_ok,
   input  logic             rd_in,
   output logic [OUT_W-1:0] code,
   output logic             rd_nxt
);
   localparam int unsigned HALF = OUT_W / 2;

   if (OUT_W != 4) begin : g_bad_w
      $error("sym_enc_4b: width fixed at 4");
   end

   logic [OUT_W-1:0] base;
   logic [OUT_W-1:0] neg_code;
   logic             alt7;
   logic             unbal;
   logic             swap;

   always_comb begin
      unique case (y_in)
         3'd0: base = 4'b1011;
         3'd1: base = 4'b1001;
         3'd2: base = 4'b0101;
         3'd3: base = 4'b1100;
         3'd4: base = 4'b1101;
         3'd5: base = 4'b1010;
         3'd6: base = 4'b0110;
         default: base = 4'b1110;
      endcase
      // R6: alternate form avoids a run of five equal bits across the sub-blocks
      alt7 = (!rd_in && (x_in == 5'd17 || x_in == 5'd18 || x_in == 5'd20)) ||
             ( rd_in && (x_in == 5'd11 || x_in == 5'd13 || x_in == 5'd14));
      neg_code = base;
      if (k_ok) begin
         if (y_in == 3'd7)
            neg_code = 4'b0111;
         else if (y_in == 3'd1 || y_in == 3'd2 || y_in == 3'd5 || y_in == 3'd6)
            neg_code = ~base;
      end else if (y_in == 3'd7 && alt7) begin
         neg_code = 4'b0111;
      end
      unbal  = ($countones(neg_code) != HALF);
      swap   = rd_in && (unbal || k_ok || y_in == 3'd3);
      code   = swap ? ~neg_code : neg_code;
      rd_nxt = rd_in ^ unbal;
   end

endmodule

// File: rtl/sym8b10b_enc.sv
module sym8b10b_enc
   import sym_enc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sym_vld,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              is_k,
   input  logic              force_en,
   input  logic              force_rd,
   output logic [CODE_W-1:0] sym_out,
   output logic              rd_out,
   output logic              kerr_out
);
   localparam int unsigned X_W  = 5;
   localparam int unsigned Y_W  = DATA_W - X_W;
   localparam int unsigned C6_W = CODE_W - SB4_W;
   localparam int unsigned MID  = CODE_W / 2;

   if (DATA_W != BYTE_W || CODE_W != SYM_W) begin : g_bad_w
      $error("sym8b10b_enc: only 8-bit in, 10-bit out is defined");
   end

   logic              rd_q;
   logic              rd_used;
   logic              rd_mid;
   logic              rd_end;
   logic              k_ok;
   logic              k_bad;
   logic [C6_W-1:0]   c6;
   logic [SB4_W-1:0]  c4;
   logic [CODE_W-1:0] sym_q;
   logic              kerr_q;

   assign rd_used = force_en ? force_rd : rd_q;
   assign k_ok    = is_k && k_legal(byte_in);
   assign k_bad   = is_k && !k_ok;

   sym_enc_6b #(.IN_W(X_W), .OUT_W(C6_W)) u_six (
      .x_in   (byte_in[X_W-1:0]),
      .k28    (k_ok && byte_in[X_W-1:0] == 5'd28),
      .rd_in  (rd_used),
      .code   (c6),
      .rd_nxt (rd_mid)
   );

   sym_enc_4b #(.OUT_W(SB4_W)) u_four (
      .y_in   (byte_in[DATA_W-1 -: Y_W]),
      .x_in   (byte_in[X_W-1:0]),
      .k_ok   (k_ok),
      .rd_in  (rd_mid),
      .code   (c4),
      .rd_nxt (rd_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= RD_NEG;
         sym_q  <= '0;
         kerr_q <= 1'b0;
      end else if (sym_vld) begin
         rd_q   <= rd_end;
         sym_q  <= {c6, c4};
         kerr_q <= k_bad;
      end
   end

   assign sym_out  = sym_q;
   assign rd_out   = rd_q;
   assign kerr_out = kerr_q;

   // R2: no strobe, no change
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_vld |=> $stable(sym_out) && $stable(rd_out) && $stable(kerr_out));

   // R4: every symbol within one bit of balance
   a_r4_balance: assert property (@(posedge clk) disable iff (!rst_n)
      sym_vld |=> ($countones(sym_out) >= MID - 1) && ($countones(sym_out) <= MID + 1));

   // R4: disparity flips exactly when the emitted symbol is unbalanced
   a_r4_rd_flip: assert property (@(posedge clk) disable iff (!rst_n)
      sym_vld |=> ((rd_out != $past(rd_used)) == ($countones(sym_out) != MID)));

   // R5: a forced symbol takes its first sub-block from the forced column
   a_r5_forced_col: assert property (@(posedge clk) disable iff (!rst_n)
      sym_vld && force_en |=> ($past(force_rd) ? ($countones(sym_out[CODE_W-1 -: C6_W]) <= 3)
                                               : ($countones(sym_out[CODE_W-1 -: C6_W]) >= 3)));

   // R8: illegal control byte raises the flag on the next cycle
   a_r8_kerr: assert property (@(posedge clk) disable iff (!rst_n)
      sym_vld && is_k && !k_legal(byte_in) |=> kerr_out);

endmodule

// File: tb/sym8b10b_enc_tb_top.sv
module sym8b10b_enc_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sym_vld = 1'b0;
   logic [7:0] byte_in = '0;
   logic       is_k = 1'b0;
   logic       force_en = 1'b0;
   logic       force_rd = 1'b0;
   logic [9:0] sym_out;
   logic       rd_out;
   logic       kerr_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference state
   logic       m_rd = 1'b0;
   logic [9:0] m_sym = '0;
   logic       m_kerr = 1'b0;

   always #5 clk = ~clk;

   sym8b10b_enc dut_i (
      .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .byte_in(byte_in),
      .is_k(is_k), .force_en(force_en), .force_rd(force_rd),
      .sym_out(sym_out), .rd_out(rd_out), .kerr_out(kerr_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // 6-bit codes listed as the negative-column form
   function automatic logic [5:0] neg6(input int x, input bit k);
      logic [5:0] t [32];
      t = '{6'h27,6'h1D,6'h2D,6'h31,6'h35,6'h29,6'h19,6'h38,
            6'h39,6'h25,6'h15,6'h34,6'h0D,6'h2C,6'h1C,6'h17,
            6'h1B,6'h23,6'h13,6'h32,6'h0B,6'h2A,6'h1A,6'h3A,
            6'h33,6'h26,6'h16,6'h36,6'h0E,6'h2E,6'h1E,6'h2B};
      if (k && x == 28) return 6'h0F;
      return t[x];
   endfunction

   function automatic int ones(input logic [9:0] v);
      int n = 0;
      for (int i = 0; i < 10; i++) n += v[i];
      return n;
   endfunction

   // behavioural reference: returns {kerr, rd_after, symbol}
   function automatic logic [11:0] ref_enc(input logic [7:0] b, input bit k,
                                           input logic rd0);
      int x = b[4:0];
      int y = b[7:5];
      bit kv = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
      logic [3:0] d4 [8];
      logic [5:0] s6;
      logic [3:0] s4;
      logic rd = rd0;
      d4 = '{4'hB, 4'h9, 4'h5, 4'hC, 4'hD, 4'hA, 4'h6, 4'hE};
      s6 = neg6(x, kv);
      if (rd && (ones({4'b0, s6}) != 3 || (x == 7 && !kv))) s6 = ~s6;
      if (ones({4'b0, s6}) != 3) rd = ~rd;
      s4 = d4[y];
      if (kv) begin
         if (y == 7) s4 = 4'h7;
         else if (y inside {1, 2, 5, 6}) s4 = ~s4;
         if (rd) s4 = ~s4;
      end else begin
         if (y == 7 && ((!rd && x inside {17, 18, 20}) || (rd && x inside {11, 13, 14})))
            s4 = 4'h7;
         if (rd && (ones({6'b0, s4}) != 2 || y == 3)) s4 = ~s4;
      end
      if (ones({6'b0, s4}) != 2) rd = ~rd;
      return {(k && !kv), rd, s6, s4};
   endfunction

   // one clock: drive at the falling edge, compare after the rising edge
   task automatic step(input logic v, input logic [7:0] b, input logic k,
                       input logic fe, input logic fv);
      logic [11:0] r;
      @(negedge clk);
      sym_vld = v; byte_in = b; is_k = k; force_en = fe; force_rd = fv;
      if (v) begin
         r = ref_enc(b, k, fe ? fv : m_rd);
         m_sym = r[9:0]; m_rd = r[10]; m_kerr = r[11];
      end
      @(posedge clk);
      #2;
      chk("R3 symbol", {22'b0, sym_out}, {22'b0, m_sym});
      chk("R9 running disparity", {31'b0, rd_out}, {31'b0, m_rd});
      chk("R8 control error", {31'b0, kerr_out}, {31'b0, m_kerr});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset symbol", {22'b0, sym_out}, 32'h0);
      chk("R1 reset disparity", {31'b0, rd_out}, 32'h0);
      chk("R1 reset kerr", {31'b0, kerr_out}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 8'hBC, 1'b1, 1'b0, 1'b0);
      chk("R1 idle after reset", {22'b0, sym_out}, 32'h0);

      // R7 K28.5 from both columns
      step(1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);
      chk("R7 K28.5 negative", {22'b0, sym_out}, 32'h0FA);
      chk("R4 rd after K28.5", {31'b0, rd_out}, 32'h1);
      step(1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);
      chk("R7 K28.5 positive", {22'b0, sym_out}, 32'h305);
      step(1'b1, 8'hFC, 1'b1, 1'b0, 1'b0);
      chk("R7 K28.7 negative", {22'b0, sym_out}, 32'h0F8);

      // R2 latency: output unchanged before the sampling edge
      @(negedge clk);
      sym_vld = 1'b1; byte_in = 8'hB5; is_k = 1'b0; force_en = 1'b0;
      #2;
      chk("R2 no early change", {22'b0, sym_out}, {22'b0, m_sym});
      step(1'b1, 8'hB5, 1'b0, 1'b0, 1'b0);
      chk("R3 D21.5", {22'b0, sym_out}, 32'h2AA);

      // R2 hold while idle with busy inputs
      step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
      step(1'b0, 8'h55, 1'b0, 1'b1, 1'b0);
      chk("R2 hold symbol", {22'b0, sym_out}, 32'h2AA);

      // R5 force both ways, then tracking resumes
      step(1'b1, 8'hBC, 1'b1, 1'b1, 1'b1);
      chk("R5 forced positive", {22'b0, sym_out}, 32'h305);
      chk("R5 rd after forced", {31'b0, rd_out}, 32'h0);
      step(1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
      chk("R3 D0.0 negative", {22'b0, sym_out}, 32'h274);
      step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0);

      // R6 alternate D.x.7
      step(1'b1, 8'hF1, 1'b0, 1'b1, 1'b0);
      chk("R6 D17.7 negative", {22'b0, sym_out}, 32'h237);
      step(1'b1, 8'hEB, 1'b0, 1'b1, 1'b1);
      chk("R6 D11.7 positive", {22'b0, sym_out}, 32'h348);

      // R8 illegal control bytes encoded as data
      step(1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
      chk("R8 flag set", {31'b0, kerr_out}, 32'h1);
      chk("R8 sent as D0.0", {22'b0, sym_out}, 32'h274);
      step(1'b1, 8'hFD, 1'b1, 1'b0, 1'b0);
      chk("R8 flag clear on K29.7", {31'b0, kerr_out}, 32'h0);

      // every legal K code and every data byte, both columns
      for (int i = 0; i < 256; i++) begin
         step(1'b1, 8'(i), 1'b0, 1'b1, 1'b0);
         step(1'b1, 8'(i), 1'b0, 1'b1, 1'b1);
         step(1'b1, 8'(i), 1'b1, 1'b0, 1'b0);
      end

      // random traffic; R4 balance checked independently of the model
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] rb = 8'($urandom);
         step(1'($urandom_range(0, 7) != 0), rb, 1'($urandom_range(0, 5) == 0),
              1'($urandom_range(0, 9) == 0), 1'($urandom));
         chk("R4 ones in range", {31'b0, (ones(sym_out) >= 4 && ones(sym_out) <= 6)}, 32'h1);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule